// File: doc/BRIEF.md
# Microcontroller Sleep Mode Controller

This block decides when the CPU and the peripherals of a small 8-bit microcontroller receive clock, and when the oscillator runs. The CPU can make two sleep requests. The light request stops only the CPU and keeps every peripheral clocked. The deep request also switches the oscillator off. The block also turns the board reset pin into an internal reset. When that pin ends a light sleep, the block first opens a guard window. For two machine cycles the CPU keeps running, while writes to internal RAM are blocked and port writes are left alone.

The clock outputs are one-cycle enable strobes at half the oscillator rate. This is the divide-by-two stage, so the duty cycle of the input clock does not matter. One machine cycle is twelve oscillator periods, which is six strobes. When the deep sleep ends, the CPU strobes stay off for a programmable number of oscillator cycles, so that the oscillator can settle. The request bits clear themselves when the block wakes.

Top module: `sleep_ctrl`

## Requirements
- R1: After power-on reset, the oscillator is enabled, the internal reset and the RAM write block are low, and both request bits read 0.
- R2: While the CPU is running, `cpu_tick` and `per_tick` are equal and pulse on exactly every second oscillator cycle.
- R3: A pulse on `idle_req` sets `idle_bit` after that clock edge. While `idle_bit` is set, `cpu_tick` stays low, `per_tick` keeps alternating and `osc_en` stays high.
- R4: In light sleep, an interrupt whose enable bit is set wakes the CPU at the next edge and clears `idle_bit`. The interrupt may be external or peripheral. An interrupt whose enable bit is clear leaves the block asleep.
- R5: A pulse on `pd_req` sets `pd_bit` and drops `osc_en`, `cpu_tick` and `per_tick` after that edge. When both requests arrive in the same cycle, the deep request wins and `idle_bit` stays 0.
- R6: In deep sleep, only an enabled external interrupt or `hw_rst` wakes the block. Enabled peripheral interrupts do not wake it, and neither do disabled ones. After a wake by interrupt, `osc_en` rises at once and `pd_bit` clears. The CPU strobes then stay low for max(`warm_len`,1) cycles. The divider then restarts from its low phase, so the first `cpu_tick` appears W+1 cycles after the wake edge when W is odd and W+2 cycles after it when W is even, where W = max(`warm_len`,1).
- R7: `hw_rst` sampled high while the CPU runs raises `int_rst` after that edge and clears both request bits. `int_rst` then stays high until one edge after `hw_rst` is sampled low. `hw_rst` also wins over a sleep request in the same cycle.
- R8: `hw_rst` in light sleep opens a guard window. For exactly 24 oscillator cycles `ram_wr_block` is high and `int_rst` is low, and `cpu_tick` pulses exactly 12 times. Then `int_rst` rises and `idle_bit` reads 0.
- R9: `hw_rst` in deep sleep enables the oscillator at once. The CPU strobes and `int_rst` stay low for max(`warm_len`,1) cycles, and then `int_rst` rises.
- R10: While `idle_bit` is set, `idle_req` and `pd_req` have no effect.
- R11: In light sleep, `hw_rst` wins over an enabled interrupt that arrives in the same cycle, and the guard window of R8 opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Power-on reset of this block, active low |
| hw_rst | input | 1 | Board reset pin, synchronous, active high |
| idle_req | input | 1 | Request from software to stop the CPU clock |
| pd_req | input | 1 | Request from software to stop the oscillator |
| ext_irq | input | N_EXT | External interrupt requests |
| ext_irq_en | input | N_EXT | Enable bits for the external interrupts |
| per_irq | input | N_PER | Peripheral interrupt requests |
| per_irq_en | input | N_PER | Enable bits for the peripheral interrupts |
| warm_len | input | WARM_W | Settling time of the oscillator, in cycles |
| cpu_tick | output | 1 | Clock enable strobe for the CPU |
| per_tick | output | 1 | Clock enable strobe for the peripherals |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Internal reset |
| ram_wr_block | output | 1 | Blocks writes to internal RAM |
| idle_bit | output | 1 | Light sleep request bit, readable |
| pd_bit | output | 1 | Deep sleep request bit, readable |

## Verification
Two pairs of events can land on the same clock edge. The first is a reset pin that rises together with an enabled interrupt during light sleep. The second is a light request and a deep request written together. The bench drives both members of each pair in one cycle. For the first pair it checks that the guard window opened, by watching `ram_wr_block` and the 12 CPU strobes, and not a plain wake. For the second it checks that only `pd_bit` is set and that the oscillator stopped. A reset pin raised together with a deep request while running is judged the same way, by `int_rst` and a cleared `pd_bit`.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_PDOWN,
        ST_WARM,
        ST_GUARD,
        ST_RHOLD
    } sc_state_e;
endpackage

// File: rtl/sc_clk_div2.sv
module sc_clk_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic phase
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (clr)
            phase_d = 1'b0;
        else if (en)
            phase_d = ~phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else
            phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R2: a running divider flips every cycle
    a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (phase != $past(phase)));
endmodule

// File: rtl/sc_wake_sel.sv
module sc_wake_sel #(
    parameter int N_EXT = 2,
    parameter int N_PER = 3
) (
    input  logic [N_EXT-1:0] ext_irq,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_PER-1:0] per_irq,
    input  logic [N_PER-1:0] per_en,
    output logic             ext_hit,
    output logic             per_hit
);
    logic [N_EXT-1:0] ext_live;
    logic [N_PER-1:0] per_live;

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        assign ext_live[i] = ext_irq[i] & ext_en[i];
    end
    for (genvar j = 0; j < N_PER; j++) begin : g_per
        assign per_live[j] = per_irq[j] & per_en[j];
    end

    assign ext_hit = |ext_live;
    assign per_hit = |per_live;
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
    parameter int N_EXT      = 2,
    parameter int N_PER      = 3,
    parameter int OSC_PER_MC = 12,
    parameter int GUARD_MC   = 2,
    parameter int WARM_W     = 8
) (
    input  logic              osc_clk,
    input  logic              por_n,
    input  logic              hw_rst,
    input  logic              idle_req,
    input  logic              pd_req,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_EXT-1:0]  ext_irq_en,
    input  logic [N_PER-1:0]  per_irq,
    input  logic [N_PER-1:0]  per_irq_en,
    input  logic [WARM_W-1:0] warm_len,
    output logic              cpu_tick,
    output logic              per_tick,
    output logic              osc_en,
    output logic              int_rst,
    output logic              ram_wr_block,
    output logic              idle_bit,
    output logic              pd_bit
);
    import sleep_ctrl_pkg::*;

    localparam int TICKS_PER_MC = OSC_PER_MC / 2;
    localparam int GUARD_TICKS  = GUARD_MC * TICKS_PER_MC;
    localparam int GUARD_CW     = $clog2(GUARD_TICKS + 1);
    localparam int CNT_W        = ((WARM_W > GUARD_CW) ? WARM_W : GUARD_CW) + 1;

    typedef struct packed {
        sc_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             rst_wake;
        logic             idle;
        logic             pd;
    } sc_regs_t;

    sc_regs_t r_d, r_q;
    logic     phase, div_clr, div_en, div_tick;
    logic     ext_hit, per_hit;
    logic [CNT_W-1:0] warm_lim;

    sc_wake_sel #(.N_EXT(N_EXT), .N_PER(N_PER)) u_wake (
        .ext_irq (ext_irq),
        .ext_en  (ext_irq_en),
        .per_irq (per_irq),
        .per_en  (per_irq_en),
        .ext_hit (ext_hit),
        .per_hit (per_hit)
    );

    assign div_en = (r_q.st != ST_PDOWN);

    sc_clk_div2 u_div (
        .clk   (osc_clk),
        .rst_n (por_n),
        .en    (div_en),
        .clr   (div_clr),
        .phase (phase)
    );

    assign div_tick = phase & div_en;
    assign warm_lim = CNT_W'(warm_len);

    always_comb begin
        r_d     = r_q;
        div_clr = 1'b0;
        case (r_q.st)
            ST_RUN: begin
                if (hw_rst) begin
                    r_d.st   = ST_RHOLD;
                    r_d.idle = 1'b0;
                    r_d.pd   = 1'b0;
                end else if (pd_req) begin
                    r_d.st = ST_PDOWN;
                    r_d.pd = 1'b1;
                end else if (idle_req) begin
                    r_d.st   = ST_IDLE;
                    r_d.idle = 1'b1;
                end
            end
            ST_IDLE: begin
                if (hw_rst) begin
                    r_d.st   = ST_GUARD;
                    r_d.idle = 1'b0;
                    r_d.cnt  = '0;
                    div_clr  = 1'b1;
                end else if (ext_hit || per_hit) begin
                    r_d.st   = ST_RUN;
                    r_d.idle = 1'b0;
                end
            end
            ST_PDOWN: begin
                if (hw_rst || ext_hit) begin
                    r_d.st       = ST_WARM;
                    r_d.rst_wake = hw_rst;
                    r_d.pd       = 1'b0;
                    r_d.cnt      = CNT_W'(1);
                    div_clr      = 1'b1;
                end
            end
            ST_WARM: begin
                if (r_q.cnt >= warm_lim) begin
                    r_d.st       = r_q.rst_wake ? ST_RHOLD : ST_RUN;
                    r_d.rst_wake = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_GUARD: begin
                if (div_tick) begin
                    if (r_q.cnt == CNT_W'(GUARD_TICKS - 1))
                        r_d.st = ST_RHOLD;
                    else
                        r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_RHOLD: begin
                if (!hw_rst)
                    r_d.st = ST_RUN;
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge osc_clk or negedge por_n) begin
        if (!por_n) begin
            r_q.st       <= ST_RUN;
            r_q.cnt      <= '0;
            r_q.rst_wake <= 1'b0;
            r_q.idle     <= 1'b0;
            r_q.pd       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_tick     = phase & ((r_q.st == ST_RUN) || (r_q.st == ST_GUARD));
    assign per_tick     = phase & ((r_q.st == ST_RUN) || (r_q.st == ST_IDLE) ||
                                   (r_q.st == ST_GUARD) || (r_q.st == ST_RHOLD));
    assign osc_en       = (r_q.st != ST_PDOWN);
    assign int_rst      = (r_q.st == ST_RHOLD);
    assign ram_wr_block = (r_q.st == ST_GUARD);
    assign idle_bit     = r_q.idle;
    assign pd_bit       = r_q.pd;

    // R2: CPU strobes never fall on adjacent cycles
    a_r2_tick_gap: assert property (@(posedge osc_clk) disable iff (!por_n)
        cpu_tick |=> !cpu_tick);
    // R3: no CPU strobe while the light sleep bit is set
    a_r3_idle_cpu: assert property (@(posedge osc_clk) disable iff (!por_n)
        idle_bit |-> !cpu_tick);
    // R4: an enabled interrupt ends light sleep
    a_r4_wake: assert property (@(posedge osc_clk) disable iff (!por_n)
        (idle_bit && !hw_rst && (ext_hit || per_hit)) |=> (!idle_bit && !ram_wr_block));
    // R5: no strobes with the oscillator stopped
    a_r5_quiet: assert property (@(posedge osc_clk) disable iff (!por_n)
        !osc_en |-> (!cpu_tick && !per_tick));
    // R6: deep sleep holds without an enabled external interrupt or reset
    a_r6_pd_hold: assert property (@(posedge osc_clk) disable iff (!por_n)
        (!osc_en && !hw_rst && !ext_hit) |=> !osc_en);
    // R7: the CPU is stopped during internal reset
    a_r7_rst_cpu_off: assert property (@(posedge osc_clk) disable iff (!por_n)
        int_rst |-> !cpu_tick);
    // R8: the guard window excludes the reset and the request bits
    a_r8_guard_excl: assert property (@(posedge osc_clk) disable iff (!por_n)
        ram_wr_block |-> (!int_rst && !idle_bit && !pd_bit));
endmodule

// File: tb/sleep_ctrl_test.sv
module sleep_ctrl_test;
    localparam int NE = 2;
    localparam int NP = 2;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          por_n, hw_rst, idle_req, pd_req;
    logic [NE-1:0] ext_irq, ext_en;
    logic [NP-1:0] per_irq, per_en;
    logic [WW-1:0] warm_len;
    logic cpu_tick, per_tick, osc_en, int_rst, ram_wr_block, idle_bit, pd_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sleep_ctrl #(.N_EXT(NE), .N_PER(NP), .WARM_W(WW)) uut (
        .osc_clk(clk), .por_n(por_n), .hw_rst(hw_rst), .idle_req(idle_req),
        .pd_req(pd_req), .ext_irq(ext_irq), .ext_irq_en(ext_en),
        .per_irq(per_irq), .per_irq_en(per_en), .warm_len(warm_len),
        .cpu_tick(cpu_tick), .per_tick(per_tick), .osc_en(osc_en),
        .int_rst(int_rst), .ram_wr_block(ram_wr_block),
        .idle_bit(idle_bit), .pd_bit(pd_bit)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic enter_idle();
        idle_req = 1'b1; tick(); idle_req = 1'b0;
    endtask

    task automatic enter_pd();
        pd_req = 1'b1; tick(); pd_req = 1'b0;
    endtask

    task automatic ext_pulse();
        ext_irq = 2'b01; ext_en = 2'b01; tick(); ext_irq = '0; ext_en = '0;
    endtask

    task automatic wait_run();
        for (int k = 0; k < 40 && !cpu_tick; k++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int ones, blocks, cticks, s, wp, expf;
        bit prev, wk;
        por_n = 0; hw_rst = 0; idle_req = 0; pd_req = 0;
        ext_irq = '0; ext_en = '0; per_irq = '0; per_en = '0; warm_len = 4'd3;
        repeat (3) tick();
        por_n = 1; tick();

        // R1 reset state
        chk_eq("R1 osc_en", osc_en, 1);
        chk_eq("R1 int_rst", int_rst, 0);
        chk_eq("R1 ram_wr_block", ram_wr_block, 0);
        chk_eq("R1 bits", {idle_bit, pd_bit}, 0);

        // R2 alternating strobes while running
        ones = 0; prev = cpu_tick;
        for (int k = 0; k < 8; k++) begin
            tick();
            chk(cpu_tick != prev, "R2 alternate", cpu_tick, !prev);
            chk_eq("R2 per equals cpu", per_tick, cpu_tick);
            ones += cpu_tick; prev = cpu_tick;
        end
        chk_eq("R2 tick count", ones, 4);

        // R3 light sleep
        enter_idle();
        chk_eq("R3 idle_bit", idle_bit, 1);
        prev = per_tick;
        for (int k = 0; k < 6; k++) begin
            chk_eq("R3 cpu off", cpu_tick, 0);
            chk_eq("R3 osc on", osc_en, 1);
            tick();
            chk(per_tick != prev, "R3 per alternate", per_tick, !prev);
            prev = per_tick;
        end
        // R10 requests ignored in light sleep
        idle_req = 1; pd_req = 1; tick(); idle_req = 0; pd_req = 0;
        chk_eq("R10 pd_bit", pd_bit, 0);
        chk_eq("R10 osc_en", osc_en, 1);
        chk_eq("R10 idle_bit", idle_bit, 1);
        ext_pulse();
        chk_eq("R4 wake", idle_bit, 0);

        // R4 sweep of all sources and enables in light sleep
        for (int v = 0; v < 256; v++) begin
            enter_idle();
            ext_irq = v[1:0]; per_irq = v[3:2]; ext_en = v[5:4]; per_en = v[7:6];
            wk = |(v[3:0] & v[7:4]);
            tick();
            ext_irq = '0; per_irq = '0; ext_en = '0; per_en = '0;
            chk_eq("R4 sweep idle_bit", idle_bit, !wk);
            if (idle_bit) ext_pulse();
            tick();
        end

        // R5 deep sleep and priority
        idle_req = 1; pd_req = 1; tick(); idle_req = 0; pd_req = 0;
        chk_eq("R5 pd_bit", pd_bit, 1);
        chk_eq("R5 idle_bit", idle_bit, 0);
        chk_eq("R5 osc_en", osc_en, 0);
        chk_eq("R5 strobes", {cpu_tick, per_tick}, 0);
        ext_pulse(); wait_run();

        // R6 sweep of wake sources in deep sleep
        warm_len = 4'd3;
        for (int v = 0; v < 256; v++) begin
            enter_pd();
            ext_irq = v[1:0]; per_irq = v[3:2]; ext_en = v[5:4]; per_en = v[7:6];
            wk = |(v[1:0] & v[5:4]);
            tick();
            ext_irq = '0; per_irq = '0; ext_en = '0; per_en = '0;
            chk_eq("R6 sweep osc_en", osc_en, wk);
            chk_eq("R6 sweep pd_bit", pd_bit, !wk);
            if (!osc_en) ext_pulse();
            wait_run();
        end

        // R6 settling time sweep
        for (int w = 0; w < 16; w++) begin
            warm_len = w[3:0];
            wait_run();
            enter_pd();
            ext_pulse();
            chk_eq("R6 osc back", osc_en, 1);
            wp = (w == 0) ? 1 : w;
            expf = wp + ((wp % 2 == 1) ? 1 : 2);
            s = 1;
            while (!cpu_tick && s < 40) begin tick(); s++; end
            chk_eq("R6 first cpu_tick", s, expf);
        end

        // R7 reset while running, same cycle as a deep request
        warm_len = 4'd3;
        hw_rst = 1; pd_req = 1; tick(); pd_req = 0;
        chk_eq("R7 int_rst", int_rst, 1);
        chk_eq("R7 pd_bit", pd_bit, 0);
        for (int k = 0; k < 5; k++) begin
            tick();
            chk_eq("R7 hold", int_rst, 1);
            chk_eq("R7 cpu off", cpu_tick, 0);
        end
        hw_rst = 0; tick();
        chk_eq("R7 release", int_rst, 0);
        wait_run();

        // R8 and R11 reset in light sleep, with an enabled interrupt in the same cycle
        enter_idle();
        hw_rst = 1; per_irq = 2'b10; per_en = 2'b10; tick();
        per_irq = '0; per_en = '0;
        chk_eq("R11 guard opened", ram_wr_block, 1);
        blocks = 0; cticks = 0;
        while (ram_wr_block && blocks < 100) begin
            blocks++;
            cticks += cpu_tick;
            chk_eq("R8 no int_rst in guard", int_rst, 0);
            tick();
        end
        chk_eq("R8 guard length", blocks, 24);
        chk_eq("R8 cpu strobes", cticks, 12);
        chk_eq("R8 int_rst after", int_rst, 1);
        chk_eq("R8 idle_bit", idle_bit, 0);
        hw_rst = 0; tick();
        chk_eq("R8 release", int_rst, 0);
        wait_run();

        // R9 reset in deep sleep
        warm_len = 4'd5;
        enter_pd();
        hw_rst = 1; tick();
        chk_eq("R9 osc_en", osc_en, 1);
        s = 1;
        while (!int_rst && s < 40) begin
            chk_eq("R9 cpu off", cpu_tick, 0);
            tick(); s++;
        end
        chk_eq("R9 reset delay", s, 6);
        hw_rst = 0; tick();
        chk_eq("R9 release", int_rst, 0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule